// File: doc/BRIEF.md
# Handshaked Wavefront Multiply-Accumulate Array

A rectangular grid of processing elements (PEs) that computes without any global schedule. Every link between neighbouring PEs, and every port at the edge of the grid, is a valid/ready channel: a word crosses the link on a clock edge where valid and ready are both high. Row operands enter at the west edge and move east. Column operands enter at the north edge and move south. An internal program memory issues one opcode per wave. The opcode rides with the row operand, so every PE in a row applies the same operation to the same wave.

A PE starts work only when three things hold: its row token (opcode, row operand and running sum) is buffered, its column operand is buffered, and both of its output buffers are empty. It keeps a private accumulator. The execute stage takes one to four cycles, picked by the low bits of the row operand, to model latency that depends on the data. When the stage finishes, the PE passes the row token east with its accumulator added to the running sum, and passes the column operand south unchanged. Work for one wave therefore spreads from the north-west corner towards the south-east corner. Stalls at the east or south edge push back through the grid, and no data is lost.

Top module: `wf_array`

## Requirements
- R1: An east or south output that is valid and not accepted stays valid, with all of its fields unchanged, on the next cycle.
- R2: While reset is held, and on the first cycle after reset is released, every east and south output is invalid.
- R3: The opcode carried with wave k on every east output is taken from program slot (k mod PROG_LEN). The opcode is 1 (clear) when the slot number mod 4 is 0, 2 (pass) when it is 3, and 0 (accumulate) otherwise. It appears on `east_op[2r+1:2r]`.
- R4: Each south output delivers exactly the words accepted on the north input of the same column, in the same order.
- R5: Each east output delivers, in `east_a`, exactly the words accepted on the west input of the same row, in the same order.
- R6: For wave k on row r, `east_sum` is the sum, modulo 2^24, of the accumulators of the row's PEs after that wave. The accumulator of PE (r,c) becomes a*b under clear, acc+a*b under accumulate, and stays as it is under pass. Here a is wave k's west word of row r and b is wave k's north word of column c.
- R7: A PE's execute stage lasts (a mod 4)+1 cycles, where a is its row operand. On an idle array with free outputs, east output 0 turns valid COLS*(L+2)-1 clock edges after the edge on which the wave is accepted on all west and north inputs, where L is that latency for row 0.
- R8: A PE that holds a row token but no column operand does not fire. A wave supplied only on the west edge produces no east or south output.
- R9: Under arbitrary stalls on the east and south outputs, every accepted input wave leaves on every east and south output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| west_valid | input | ROWS | Row operand valid, one bit per row |
| west_data | input | ROWS*8 | Row operands, row r at bits [8r+7:8r] |
| west_ready | output | ROWS | Row operand accepted when high with valid |
| north_valid | input | COLS | Column operand valid, one bit per column |
| north_data | input | COLS*8 | Column operands, column c at bits [8c+7:8c] |
| north_ready | output | COLS | Column operand accepted when high with valid |
| east_valid | output | ROWS | Row result valid |
| east_op | output | ROWS*2 | Opcode applied to the wave |
| east_a | output | ROWS*8 | Row operand passed through |
| east_sum | output | ROWS*24 | Running sum of the row's accumulators |
| east_ready | input | ROWS | Row result taken |
| south_valid | output | COLS | Column operand out valid |
| south_data | output | COLS*8 | Column operand passed through |
| south_ready | input | COLS | Column operand out taken |

## Verification
The case of interest is a PE firing, which empties its input buffers, on the same edge that its west or north neighbour writes the next token into those same buffers. The refill and the drain meet in one register. The random phase drives gap-free streams often enough that each PE is refilled in its firing cycle, while random stalls at the east and south edges make the timing uneven. Any lost, doubled or reordered token then appears as a mismatch in the per-link sequence or in the accumulated sums computed by the bench model.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int unsigned WF_DW       = 8;
    localparam int unsigned WF_SW       = 24;
    localparam int unsigned WF_LAT_BITS = 2;
    localparam int unsigned WF_OP_MOD   = 4;

    typedef enum logic [1:0] {
        OP_MAC  = 2'd0,
        OP_CLR  = 2'd1,
        OP_PASS = 2'd2
    } wf_op_e;

    typedef logic [WF_DW-1:0] wf_word_t;
    typedef logic [WF_SW-1:0] wf_sum_t;

    // token travelling eastwards along a row
    typedef struct packed {
        wf_op_e   op;
        wf_word_t a;
        wf_sum_t  sum;
    } wf_htok_t;

    // operands held by the execute stage
    typedef struct packed {
        wf_op_e   op;
        wf_word_t a;
        wf_word_t b;
        wf_sum_t  sum;
    } wf_exec_t;

    function automatic wf_op_e prog_op(input int unsigned slot);
        case (slot % WF_OP_MOD)
            0:       return OP_CLR;
            3:       return OP_PASS;
            default: return OP_MAC;
        endcase
    endfunction

    function automatic logic [WF_LAT_BITS:0] exec_cycles(input wf_word_t a);
        return {1'b0, a[WF_LAT_BITS-1:0]} + 1'b1;
    endfunction

    function automatic wf_sum_t step_acc(input wf_op_e op, input wf_sum_t acc,
                                         input wf_word_t a, input wf_word_t b);
        wf_sum_t prod;
        prod = wf_sum_t'(a) * wf_sum_t'(b);
        case (op)
            OP_CLR:  return prod;
            OP_MAC:  return acc + prod;
            default: return acc;
        endcase
    endfunction

endpackage

// File: rtl/wf_prog_issue.sv
module wf_prog_issue
    import wf_pkg::*;
#(
    parameter int unsigned ROWS     = 3,
    parameter int unsigned PROG_LEN = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [ROWS-1:0] valid_o,
    output wf_op_e          op_o,
    input  logic [ROWS-1:0] ready_i
);

    localparam int unsigned PC_W = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;

    wf_op_e          rom [PROG_LEN];
    logic [PC_W-1:0] pc_q;
    logic [ROWS-1:0] full_q;
    logic [ROWS-1:0] take;
    logic [ROWS-1:0] row_free;
    wf_op_e          op_q;
    logic            issue;

    always_comb begin
        for (int i = 0; i < int'(PROG_LEN); i++) begin
            rom[i] = prog_op(i);
        end
    end

    // a row slot is free when empty or being emptied this cycle
    assign take     = full_q & ready_i;
    assign row_free = ~full_q | take;
    assign issue    = &row_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            full_q <= '0;
            op_q   <= OP_MAC;
        end else if (issue) begin
            full_q <= '1;
            op_q   <= rom[pc_q];
            pc_q   <= (pc_q == PC_W'(PROG_LEN - 1)) ? '0 : pc_q + 1'b1;
        end else begin
            full_q <= full_q & ~take;
        end
    end

    assign valid_o = full_q;
    assign op_o    = op_q;

endmodule

// File: rtl/wf_west_join.sv
module wf_west_join
    import wf_pkg::*;
(
    input  logic     a_valid_i,
    input  wf_word_t a_data_i,
    output logic     a_ready_o,
    input  logic     op_valid_i,
    input  wf_op_e   op_i,
    output logic     op_ready_o,
    output logic     valid_o,
    output wf_htok_t data_o,
    input  logic     ready_i
);

    // both streams advance together or not at all
    assign valid_o    = a_valid_i & op_valid_i;
    assign a_ready_o  = ready_i & op_valid_i;
    assign op_ready_o = ready_i & a_valid_i;
    assign data_o     = '{op: op_i, a: a_data_i, sum: '0};

endmodule

// File: rtl/wf_pe.sv
module wf_pe
    import wf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   h_valid_i,
    input  wf_htok_t               h_data_i,
    output logic                   h_ready_o,
    input  logic                   v_valid_i,
    input  wf_word_t               v_data_i,
    output logic                   v_ready_o,
    output logic                   h_valid_o,
    output wf_htok_t               h_data_o,
    input  logic                   h_ready_i,
    output logic                   v_valid_o,
    output wf_word_t               v_data_o,
    input  logic                   v_ready_i,
    output logic                   fire_o,
    output logic                   done_o,
    output logic [WF_LAT_BITS:0]   lat_o
);

    wf_htok_t               hin_q;
    logic                   hin_full;
    wf_word_t               vin_q;
    logic                   vin_full;
    wf_exec_t               ex_q;
    logic                   ex_busy;
    logic [WF_LAT_BITS-1:0] ex_cnt;
    wf_sum_t                acc_q;
    wf_sum_t                acc_next;
    wf_htok_t               hout_q;
    logic                   hout_full;
    wf_word_t               vout_q;
    logic                   vout_full;
    logic                   fire;
    logic                   done;

    assign fire     = hin_full & vin_full & ~ex_busy & ~hout_full & ~vout_full;
    assign done     = ex_busy & (ex_cnt == '0);
    assign acc_next = step_acc(ex_q.op, acc_q, ex_q.a, ex_q.b);

    // a buffer consumed this cycle may be refilled on the same edge
    assign h_ready_o = ~hin_full | fire;
    assign v_ready_o = ~vin_full | fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            hin_q     <= '0;
            hin_full  <= 1'b0;
            vin_q     <= '0;
            vin_full  <= 1'b0;
        end else begin
            if (h_valid_i && h_ready_o) begin
                hin_q    <= h_data_i;
                hin_full <= 1'b1;
            end else if (fire) begin
                hin_full <= 1'b0;
            end
            if (v_valid_i && v_ready_o) begin
                vin_q    <= v_data_i;
                vin_full <= 1'b1;
            end else if (fire) begin
                vin_full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q    <= '0;
            ex_busy <= 1'b0;
            ex_cnt  <= '0;
        end else if (fire) begin
            ex_busy <= 1'b1;
            ex_cnt  <= hin_q.a[WF_LAT_BITS-1:0];
            ex_q    <= '{op: hin_q.op, a: hin_q.a, b: vin_q, sum: hin_q.sum};
        end else if (done) begin
            ex_busy <= 1'b0;
        end else if (ex_busy) begin
            ex_cnt  <= ex_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            hout_q    <= '0;
            hout_full <= 1'b0;
            vout_q    <= '0;
            vout_full <= 1'b0;
        end else if (done) begin
            acc_q     <= acc_next;
            hout_q    <= '{op: ex_q.op, a: ex_q.a, sum: ex_q.sum + acc_next};
            hout_full <= 1'b1;
            vout_q    <= ex_q.b;
            vout_full <= 1'b1;
        end else begin
            if (h_ready_i) hout_full <= 1'b0;
            if (v_ready_i) vout_full <= 1'b0;
        end
    end

    assign h_valid_o = hout_full;
    assign h_data_o  = hout_q;
    assign v_valid_o = vout_full;
    assign v_data_o  = vout_q;
    assign fire_o    = fire;
    assign done_o    = done;
    assign lat_o     = exec_cycles(hin_q.a);

endmodule

// File: rtl/wf_array.sv
module wf_array
    import wf_pkg::*;
#(
    parameter int unsigned ROWS     = 3,
    parameter int unsigned COLS     = 3,
    parameter int unsigned PROG_LEN = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ROWS-1:0]       west_valid,
    input  logic [ROWS*WF_DW-1:0] west_data,
    output logic [ROWS-1:0]       west_ready,
    input  logic [COLS-1:0]       north_valid,
    input  logic [COLS*WF_DW-1:0] north_data,
    output logic [COLS-1:0]       north_ready,
    output logic [ROWS-1:0]       east_valid,
    output logic [ROWS*2-1:0]     east_op,
    output logic [ROWS*WF_DW-1:0] east_a,
    output logic [ROWS*WF_SW-1:0] east_sum,
    input  logic [ROWS-1:0]       east_ready,
    output logic [COLS-1:0]       south_valid,
    output logic [COLS*WF_DW-1:0] south_data,
    input  logic [COLS-1:0]       south_ready
);

    localparam int unsigned NPE   = ROWS * COLS;
    localparam int unsigned LAT_W = WF_LAT_BITS + 1;

    wf_htok_t h_dat [ROWS][COLS+1];
    logic     h_val [ROWS][COLS+1];
    logic     h_rdy [ROWS][COLS+1];
    wf_word_t v_dat [ROWS+1][COLS];
    logic     v_val [ROWS+1][COLS];
    logic     v_rdy [ROWS+1][COLS];

    logic [ROWS-1:0]      ins_valid;
    logic [ROWS-1:0]      ins_ready;
    wf_op_e               ins_op;
    logic [NPE-1:0]       pe_fire;
    logic [NPE-1:0]       pe_done;
    logic [NPE*LAT_W-1:0] pe_lat;

    wf_prog_issue #(
        .ROWS     (ROWS),
        .PROG_LEN (PROG_LEN)
    ) i_issue (
        .clk     (clk),
        .rst     (rst),
        .valid_o (ins_valid),
        .op_o    (ins_op),
        .ready_i (ins_ready)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row_edge
        wf_west_join i_join (
            .a_valid_i  (west_valid[r]),
            .a_data_i   (west_data[r*WF_DW +: WF_DW]),
            .a_ready_o  (west_ready[r]),
            .op_valid_i (ins_valid[r]),
            .op_i       (ins_op),
            .op_ready_o (ins_ready[r]),
            .valid_o    (h_val[r][0]),
            .data_o     (h_dat[r][0]),
            .ready_i    (h_rdy[r][0])
        );
        assign east_valid[r]               = h_val[r][COLS];
        assign east_op[r*2 +: 2]           = h_dat[r][COLS].op;
        assign east_a[r*WF_DW +: WF_DW]    = h_dat[r][COLS].a;
        assign east_sum[r*WF_SW +: WF_SW]  = h_dat[r][COLS].sum;
        assign h_rdy[r][COLS]              = east_ready[r];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col_edge
        assign v_val[0][c]                  = north_valid[c];
        assign v_dat[0][c]                  = north_data[c*WF_DW +: WF_DW];
        assign north_ready[c]               = v_rdy[0][c];
        assign south_valid[c]               = v_val[ROWS][c];
        assign south_data[c*WF_DW +: WF_DW] = v_dat[ROWS][c];
        assign v_rdy[ROWS][c]               = south_ready[c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int unsigned IDX = r * COLS + c;
            wf_pe i_pe (
                .clk       (clk),
                .rst       (rst),
                .h_valid_i (h_val[r][c]),
                .h_data_i  (h_dat[r][c]),
                .h_ready_o (h_rdy[r][c]),
                .v_valid_i (v_val[r][c]),
                .v_data_i  (v_dat[r][c]),
                .v_ready_o (v_rdy[r][c]),
                .h_valid_o (h_val[r][c+1]),
                .h_data_o  (h_dat[r][c+1]),
                .h_ready_i (h_rdy[r][c+1]),
                .v_valid_o (v_val[r+1][c]),
                .v_data_o  (v_dat[r+1][c]),
                .v_ready_i (v_rdy[r+1][c]),
                .fire_o    (pe_fire[IDX]),
                .done_o    (pe_done[IDX]),
                .lat_o     (pe_lat[IDX*LAT_W +: LAT_W])
            );
        end
    end

endmodule

// File: rtl/wf_array_chk.sv
module wf_array_chk
    import wf_pkg::*;
#(
    parameter int unsigned ROWS = 3,
    parameter int unsigned COLS = 3
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic [ROWS-1:0]                      east_valid,
    input logic [ROWS-1:0]                      east_ready,
    input logic [ROWS*2-1:0]                    east_op,
    input logic [ROWS*WF_DW-1:0]                east_a,
    input logic [ROWS*WF_SW-1:0]                east_sum,
    input logic [COLS-1:0]                      south_valid,
    input logic [COLS-1:0]                      south_ready,
    input logic [COLS*WF_DW-1:0]                south_data,
    input logic [ROWS*COLS-1:0]                 pe_fire,
    input logic [ROWS*COLS-1:0]                 pe_done,
    input logic [ROWS*COLS*(WF_LAT_BITS+1)-1:0] pe_lat
);

    localparam int unsigned NPE   = ROWS * COLS;
    localparam int unsigned LAT_W = WF_LAT_BITS + 1;

    for (genvar r = 0; r < ROWS; r++) begin : g_east
        AST_EAST_HOLD: assert property (@(posedge clk) disable iff (rst)
            east_valid[r] && !east_ready[r] |=> east_valid[r]
                && $stable(east_op[r*2 +: 2]) && $stable(east_a[r*WF_DW +: WF_DW])
                && $stable(east_sum[r*WF_SW +: WF_SW])); // R1
        AST_EAST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !east_valid[r]); // R2
    end

    for (genvar c = 0; c < COLS; c++) begin : g_south
        AST_SOUTH_HOLD: assert property (@(posedge clk) disable iff (rst)
            south_valid[c] && !south_ready[c] |=> south_valid[c]
                && $stable(south_data[c*WF_DW +: WF_DW])); // R1
        AST_SOUTH_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !south_valid[c]); // R2
    end

    for (genvar i = 0; i < NPE; i++) begin : g_pe
        logic [LAT_W:0]   age_q;
        logic [LAT_W-1:0] want_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q  <= '0;
                want_q <= '0;
            end else if (pe_fire[i]) begin
                age_q  <= 1;
                want_q <= pe_lat[i*LAT_W +: LAT_W];
            end else if (age_q != '0 && age_q != '1) begin
                age_q  <= age_q + 1'b1;
            end
        end
        AST_EXEC_CYCLES: assert property (@(posedge clk) disable iff (rst)
            pe_done[i] |-> age_q == {1'b0, want_q}); // R7
        AST_FIRE_NOT_DURING_EXEC: assert property (@(posedge clk) disable iff (rst)
            pe_fire[i] |=> !pe_fire[i]); // R7
    end

endmodule

bind wf_array wf_array_chk #(
    .ROWS (ROWS),
    .COLS (COLS)
) i_wf_array_chk (
    .clk         (clk),
    .rst         (rst),
    .east_valid  (east_valid),
    .east_ready  (east_ready),
    .east_op     (east_op),
    .east_a      (east_a),
    .east_sum    (east_sum),
    .south_valid (south_valid),
    .south_ready (south_ready),
    .south_data  (south_data),
    .pe_fire     (pe_fire),
    .pe_done     (pe_done),
    .pe_lat      (pe_lat)
);

// File: tb/test_wf_array.sv
module test_wf_array;
    import wf_pkg::*;

    localparam int ROWS     = 3;
    localparam int COLS     = 3;
    localparam int PROG_LEN = 8;
    localparam int NW       = 64;
    localparam int NDIR     = 4;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [ROWS-1:0]       west_valid = '0;
    logic [ROWS*WF_DW-1:0] west_data  = '0;
    logic [ROWS-1:0]       west_ready;
    logic [COLS-1:0]       north_valid = '0;
    logic [COLS*WF_DW-1:0] north_data  = '0;
    logic [COLS-1:0]       north_ready;
    logic [ROWS-1:0]       east_valid;
    logic [ROWS*2-1:0]     east_op;
    logic [ROWS*WF_DW-1:0] east_a;
    logic [ROWS*WF_SW-1:0] east_sum;
    logic [ROWS-1:0]       east_ready = '0;
    logic [COLS-1:0]       south_valid;
    logic [COLS*WF_DW-1:0] south_data;
    logic [COLS-1:0]       south_ready = '0;

    wf_array #(.ROWS(ROWS), .COLS(COLS), .PROG_LEN(PROG_LEN)) i_wf_array (
        .clk(clk), .rst(rst),
        .west_valid(west_valid), .west_data(west_data), .west_ready(west_ready),
        .north_valid(north_valid), .north_data(north_data), .north_ready(north_ready),
        .east_valid(east_valid), .east_op(east_op), .east_a(east_a), .east_sum(east_sum),
        .east_ready(east_ready),
        .south_valid(south_valid), .south_data(south_data), .south_ready(south_ready)
    );

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    wf_word_t a_in  [ROWS][NW];
    wf_word_t b_in  [COLS][NW];
    int       x_op  [NW];
    wf_sum_t  x_sum [ROWS][NW];

    int w_idx [ROWS];
    int n_idx [COLS];
    int e_idx [ROWS];
    int s_idx [COLS];
    int lim_w = 0;
    int lim_n = 0;
    bit directed = 1;
    bit ports_on = 0;
    int commit_cyc = 0;
    int seen_cyc   = 0;

    logic [ROWS-1:0] e_stall = '0;
    logic [COLS-1:0] s_stall = '0;
    logic [ROWS*2-1:0]     e_op_prev;
    logic [ROWS*WF_DW-1:0] e_a_prev;
    logic [ROWS*WF_SW-1:0] e_sum_prev;
    logic [COLS*WF_DW-1:0] s_prev;

    task automatic check_eq(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int model_op(input int k);
        int s;
        s = (k % PROG_LEN) % 4;
        if (s == 0) return 1;
        if (s == 3) return 2;
        return 0;
    endfunction

    task automatic build_model();
        wf_sum_t acc [ROWS][COLS];
        wf_sum_t p;
        wf_sum_t s;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) acc[r][c] = '0;
        for (int k = 0; k < NW; k++) begin
            for (int r = 0; r < ROWS; r++) a_in[r][k] = wf_word_t'($urandom);
            for (int c = 0; c < COLS; c++) b_in[c][k] = wf_word_t'($urandom);
            if (k < NDIR) a_in[0][k][1:0] = 2'(k);
            x_op[k] = model_op(k);
            for (int r = 0; r < ROWS; r++) begin
                s = '0;
                for (int c = 0; c < COLS; c++) begin
                    p = wf_sum_t'(a_in[r][k]) * wf_sum_t'(b_in[c][k]);
                    if (x_op[k] == 1)      acc[r][c] = p;
                    else if (x_op[k] == 0) acc[r][c] = acc[r][c] + p;
                    s = s + acc[r][c];
                end
                x_sum[r][k] = s;
            end
        end
    endtask

    function automatic bit all_out(input int n);
        for (int r = 0; r < ROWS; r++) if (e_idx[r] < n) return 0;
        for (int c = 0; c < COLS; c++) if (s_idx[c] < n) return 0;
        return 1;
    endfunction

    // port driver and monitor, all work at the falling edge
    initial begin
        for (int r = 0; r < ROWS; r++) begin w_idx[r] = 0; e_idx[r] = 0; end
        for (int c = 0; c < COLS; c++) begin n_idx[c] = 0; s_idx[c] = 0; end
        forever begin
            @(negedge clk);
            if (ports_on) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (w_idx[r] < lim_w && (directed || $urandom_range(3) != 0)) begin
                        west_valid[r] = 1'b1;
                        west_data[r*WF_DW +: WF_DW] = a_in[r][w_idx[r]];
                    end else begin
                        west_valid[r] = 1'b0;
                    end
                    if (west_valid[r] && west_ready[r]) begin
                        if (r == 0) commit_cyc = cyc;
                        w_idx[r]++;
                    end
                end
                for (int c = 0; c < COLS; c++) begin
                    if (n_idx[c] < lim_n && (directed || $urandom_range(3) != 0)) begin
                        north_valid[c] = 1'b1;
                        north_data[c*WF_DW +: WF_DW] = b_in[c][n_idx[c]];
                    end else begin
                        north_valid[c] = 1'b0;
                    end
                    if (north_valid[c] && north_ready[c]) n_idx[c]++;
                end
                for (int r = 0; r < ROWS; r++) begin
                    if (e_stall[r]) begin
                        check_eq("R1", "east held valid", longint'(east_valid[r]), 1);
                        check_eq("R1", "east held sum", longint'(east_sum[r*WF_SW +: WF_SW]),
                                 longint'(e_sum_prev[r*WF_SW +: WF_SW]));
                        check_eq("R1", "east held a", longint'(east_a[r*WF_DW +: WF_DW]),
                                 longint'(e_a_prev[r*WF_DW +: WF_DW]));
                    end
                    east_ready[r] = directed ? 1'b1 : ($urandom_range(2) != 0);
                    if (east_valid[r] && east_ready[r]) begin
                        e_stall[r] = 1'b0;
                        if (r == 0) seen_cyc = cyc;
                        if (e_idx[r] >= NW) begin
                            check_eq("R9", "extra east token", e_idx[r], NW - 1);
                        end else begin
                            check_eq("R3", "east op", longint'(east_op[r*2 +: 2]), x_op[e_idx[r]]);
                            check_eq("R5", "east a", longint'(east_a[r*WF_DW +: WF_DW]),
                                     longint'(a_in[r][e_idx[r]]));
                            check_eq("R6", "east sum", longint'(east_sum[r*WF_SW +: WF_SW]),
                                     longint'(x_sum[r][e_idx[r]]));
                        end
                        e_idx[r]++;
                    end else begin
                        e_stall[r] = east_valid[r];
                    end
                end
                e_op_prev  = east_op;
                e_a_prev   = east_a;
                e_sum_prev = east_sum;
                for (int c = 0; c < COLS; c++) begin
                    if (s_stall[c]) begin
                        check_eq("R1", "south held valid", longint'(south_valid[c]), 1);
                        check_eq("R1", "south held data", longint'(south_data[c*WF_DW +: WF_DW]),
                                 longint'(s_prev[c*WF_DW +: WF_DW]));
                    end
                    south_ready[c] = directed ? 1'b1 : ($urandom_range(2) != 0);
                    if (south_valid[c] && south_ready[c]) begin
                        s_stall[c] = 1'b0;
                        if (s_idx[c] >= NW) begin
                            check_eq("R9", "extra south token", s_idx[c], NW - 1);
                        end else begin
                            check_eq("R4", "south data", longint'(south_data[c*WF_DW +: WF_DW]),
                                     longint'(b_in[c][s_idx[c]]));
                        end
                        s_idx[c]++;
                    end else begin
                        s_stall[c] = south_valid[c];
                    end
                end
                s_prev = south_data;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int unsigned seed_set;
        int lat;
        seed_set = $urandom(32'd424242);
        build_model();
        repeat (3) @(negedge clk);
        check_eq("R2", "east valid in reset", longint'(east_valid), 0);
        check_eq("R2", "south valid in reset", longint'(south_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R2", "east valid after reset", longint'(east_valid), 0);
        check_eq("R2", "south valid after reset", longint'(south_valid), 0);
        ports_on = 1;
        repeat (4) @(negedge clk);

        // latency of one wave on an idle array, one per latency code
        for (int k = 0; k < NDIR; k++) begin
            lim_w = k + 1;
            lim_n = k + 1;
            while (!all_out(k + 1)) @(negedge clk);
            lat = k + 1;
            check_eq("R7", "idle row-0 edges to east", seen_cyc - commit_cyc - 1, COLS * (lat + 2) - 1);
            repeat (3) @(negedge clk);
        end

        // row operand without column operand must not fire
        lim_w = NDIR + 1;
        repeat (40) @(negedge clk);
        check_eq("R8", "east valid without north word", longint'(east_valid), 0);
        check_eq("R8", "south valid without north word", longint'(south_valid), 0);
        check_eq("R8", "east count without north word", e_idx[0], NDIR);
        lim_n = NDIR + 1;
        while (!all_out(NDIR + 1)) @(negedge clk);

        // random streams with back-pressure
        directed = 0;
        lim_w = NW;
        lim_n = NW;
        while (!all_out(NW)) @(negedge clk);
        repeat (20) @(negedge clk);
        for (int r = 0; r < ROWS; r++) check_eq("R9", "east token count", e_idx[r], NW);
        for (int c = 0; c < COLS; c++) check_eq("R9", "south token count", s_idx[c], NW);
        check_eq("R9", "east idle at end", longint'(east_valid), 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        wait (cyc >= WD_LIMIT);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

endmodule